// File: doc/BRIEF.md
# Flash Page Program Buffer

This block handles the data phase of a page program command inside a serial NOR flash slave model. A serial front end, not part of this block, delivers whole bytes together with the chip-select level. The block checks the opcode and takes the three address bytes. It then stores each data byte in a 256-byte page buffer. The write position starts at the low address byte and wraps inside the addressed page. A 256-bit mask records which offsets were filled.

When chip select rises on a clean byte boundary and the command is well formed, the block commits the buffer to an on-block array model. A sweep engine visits the 256 offsets in order, one per cycle. At each offset that was filled, it replaces the stored byte with the old byte ANDed with the new data, so programming can only clear bits. A programming delay of `PROG_CYCLES` cycles follows the sweep. The busy flag covers both the sweep and the delay. When the delay ends, busy and the write-enable latch clear together.

Top module: `ppb_page_program`

## Requirements
- R1: After reset, busy and wel read 0 and every array byte reads 8'hFF.
- R2: A pulse on wel_set sets wel. A page program issued while wel is 0 changes no array byte and leaves busy at 0.
- R3: A command is the opcode 8'h02 followed by three address bytes, most significant first. The page is address bits [PAGE_W+7:8]; higher address bits are ignored. The start offset is address bits [7:0]. Any other opcode is ignored.
- R4: Data bytes go to consecutive offsets. The offset after 255 is 0 of the same page, and the neighbouring page is never touched.
- R5: When more than 256 data bytes arrive, each offset keeps the last byte sent to it. Earlier bytes are discarded.
- R6: Offsets that received no data byte in the command keep their previous array value.
- R7: If chip select rises while a byte is only partly shifted in (mid_byte = 1), nothing is programmed and wel is unchanged.
- R8: A programmed byte becomes the old byte bitwise ANDed with the received byte.
- R9: A command with no data byte, or with fewer than three address bytes, programs nothing and does not raise busy.
- R10: On a valid commit, busy rises in the cycle after chip select rises. It stays high for exactly 256 + PROG_CYCLES cycles. It falls in the same cycle that wel clears.
- R11: Any command started while busy is high is ignored entirely. It disturbs neither the buffer being committed nor any other page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| byte_valid | input | 1 | One complete byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| mid_byte | input | 1 | High while a byte is partly shifted in |
| wel_set | input | 1 | Write-enable set pulse |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Write in progress |
| rd_addr | input | PAGE_W+8 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
The bench aims at the offset pointer at the page edge. A pointer that carried into the next page would corrupt the neighbouring page, which the bench's full-array compare exposes. Streams longer than a page check that the last writer wins per offset, and short streams check that unwritten offsets are preserved. A design that cleared the whole page, or used plain stores instead of AND, would fail the overlapping re-program.

The rejection cases are also exercised:
- a missing WEL;
- a wrong opcode;
- no data bytes;
- a truncated address;
- a chip-select rise in the middle of a byte.

Each must leave the array and busy untouched.

A command injected during the sweep must not clear the mask or redirect the commit. The exact busy length catches an off-by-one in the sweep or the timer.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the page program buffer.
package ppb_pkg;
    localparam int unsigned PAGE_BYTES = 256;
    localparam int unsigned OFF_W      = 8;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SWEEP = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/ppb_cmd_tracker.sv
`timescale 1ns/1ps
// Command tracker: follows the byte stream of one chip-select window.
// Checks the opcode, takes the page and the start offset from the
// address, streams data bytes to the page buffer with a wrapping
// pointer, and raises commit on a clean chip-select rise.
// Assumes: bytes arrive only while sel_n is low, never in the cycle
// in which sel_n falls; PAGE_W <= 8.
module ppb_cmd_tracker #(
    parameter int unsigned PAGE_W    = 2,
    parameter logic [7:0]  PP_OPCODE = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              mid_byte,
    input  logic              busy,
    input  logic              wel,
    output logic              buf_clr,
    output logic              buf_we,
    output logic [7:0]        buf_off,
    output logic [7:0]        buf_wdata,
    output logic              commit,
    output logic [PAGE_W-1:0] commit_page
);
    localparam logic [2:0] PH_DATA = 3'd4;

    logic              sel_q;
    logic              armed;
    logic [2:0]        phase;
    logic              have_data;
    logic [7:0]        ptr;
    logic [PAGE_W-1:0] page_q;
    logic              fall;
    logic              rise;
    logic              take;

    // Chip-select edge detection and byte acceptance.
    always_comb begin
        fall = sel_q & ~sel_n;
        rise = ~sel_q & sel_n;
        take = byte_valid & ~sel_n & ~fall & armed;
    end

    // Byte sequencing: opcode, three address bytes, then data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b1;
            armed     <= 1'b0;
            phase     <= 3'd0;
            have_data <= 1'b0;
            ptr       <= 8'd0;
            page_q    <= '0;
        end else begin
            sel_q <= sel_n;
            if (fall) begin
                armed     <= ~busy;
                phase     <= 3'd0;
                have_data <= 1'b0;
            end else if (rise) begin
                armed <= 1'b0;
            end else if (take) begin
                case (phase)
                    3'd0: begin
                        if (byte_data != PP_OPCODE) armed <= 1'b0;
                        phase <= 3'd1;
                    end
                    3'd1: phase <= 3'd2;
                    3'd2: begin
                        page_q <= byte_data[PAGE_W-1:0];
                        phase  <= 3'd3;
                    end
                    3'd3: begin
                        ptr   <= byte_data;
                        phase <= PH_DATA;
                    end
                    default: begin
                        ptr       <= ptr + 8'd1;
                        have_data <= 1'b1;
                    end
                endcase
            end
        end
    end

    // Buffer write port and commit request.
    always_comb begin
        buf_clr     = fall & ~busy;
        buf_we      = take & (phase == PH_DATA);
        buf_off     = ptr;
        buf_wdata   = byte_data;
        commit      = rise & armed & (phase == PH_DATA) & have_data & ~mid_byte & wel;
        commit_page = page_q;
    end

    p_no_fill_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy);

    p_data_only_after_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> armed && !sel_n);
endmodule

// File: rtl/ppb_page_buffer.sv
`timescale 1ns/1ps
// Page buffer: 256 data bytes plus a filled-offset mask.
// clr empties the mask at the start of a command; a write stores one
// byte and marks its offset. One combinational read port serves the
// commit sweep.
// Assumes: clr and we are never high in the same cycle.
module ppb_page_buffer
    import ppb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       we,
    input  logic [7:0] off,
    input  logic [7:0] wdata,
    input  logic [7:0] rd_off,
    output logic [7:0] rd_data,
    output logic       rd_valid
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    // Data storage: last write per offset wins.
    always_ff @(posedge clk) begin
        if (we) data_q[off] <= wdata;
    end

    // Filled-offset mask: cleared per command, set per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q[off] <= 1'b1;
        end
    end

    // Sweep read port.
    always_comb begin
        rd_data  = data_q[rd_off];
        rd_valid = mask_q[rd_off];
    end

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_q == '0));
endmodule

// File: rtl/ppb_array_engine.sv
`timescale 1ns/1ps
// Array engine: holds the array model and runs a commit.
// A commit sweeps offsets 0..255 of the chosen page, one per cycle,
// ANDing each filled buffer byte into the array, then waits
// PROG_CYCLES cycles. busy covers sweep and wait; done pulses in the
// last wait cycle.
// Assumes: commit is honoured only while idle; PROG_CYCLES >= 1.
module ppb_array_engine
    import ppb_pkg::*;
#(
    parameter int unsigned PAGE_W      = 2,
    parameter int unsigned PROG_CYCLES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [PAGE_W-1:0]   commit_page,
    input  logic [7:0]          buf_data,
    input  logic                buf_valid,
    output logic [7:0]          buf_rd_off,
    output logic                busy,
    output logic                done,
    input  logic [PAGE_W+7:0]   rd_addr,
    output logic [7:0]          rd_data
);
    localparam int unsigned DEPTH = (1 << PAGE_W) * PAGE_BYTES;
    localparam int unsigned TMR_W = $clog2(PROG_CYCLES + 1);
    localparam logic [TMR_W-1:0] T_LAST = TMR_W'(PROG_CYCLES - 1);

    eng_state_t        state;
    logic [7:0]        off;
    logic [PAGE_W-1:0] page_q;
    logic [TMR_W-1:0]  timer;
    logic [7:0]        mem [DEPTH];

    // Commit sequencing and 1-to-0 array programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            off    <= 8'd0;
            page_q <= '0;
            timer  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (commit) begin
                        state  <= ENG_SWEEP;
                        off    <= 8'd0;
                        page_q <= commit_page;
                    end
                end
                ENG_SWEEP: begin
                    if (buf_valid) mem[{page_q, off}] <= mem[{page_q, off}] & buf_data;
                    off <= off + 8'd1;
                    if (off == 8'hFF) begin
                        state <= ENG_WAIT;
                        timer <= '0;
                    end
                end
                ENG_WAIT: begin
                    if (timer == T_LAST) state <= ENG_IDLE;
                    else                 timer <= timer + 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Status and read ports.
    always_comb begin
        busy       = (state != ENG_IDLE);
        done       = (state == ENG_WAIT) && (timer == T_LAST);
        buf_rd_off = off;
        rd_data    = mem[rd_addr];
    end

    p_commit_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (state == ENG_IDLE));

    p_wait_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_WAIT) |-> (timer < PROG_CYCLES));

    p_sweep_continues_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_SWEEP && off != 8'hFF) |=> (state == ENG_SWEEP));
endmodule

// File: rtl/ppb_page_program.sv
`timescale 1ns/1ps
// Page program buffer top: write-enable latch, command tracker,
// page buffer and array engine. The write-enable latch is set by
// wel_set and cleared when a commit finishes.
// Assumes: 2 <= ARRAY_PAGES <= 256, power of two; PROG_CYCLES >= 1.
module ppb_page_program #(
    parameter int unsigned ARRAY_PAGES = 4,
    parameter int unsigned PROG_CYCLES = 32,
    parameter logic [7:0]  PP_OPCODE   = 8'h02,
    localparam int unsigned PAGE_W     = $clog2(ARRAY_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              mid_byte,
    input  logic              wel_set,
    output logic              wel,
    output logic              busy,
    input  logic [PAGE_W+7:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic              buf_clr;
    logic              buf_we;
    logic [7:0]        buf_off;
    logic [7:0]        buf_wdata;
    logic              commit;
    logic [PAGE_W-1:0] commit_page;
    logic [7:0]        sweep_off;
    logic [7:0]        sweep_data;
    logic              sweep_valid;
    logic              done;
    logic              wel_q;

    // Write-enable latch: completion clears it ahead of a set.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_q <= 1'b0;
        else if (done)    wel_q <= 1'b0;
        else if (wel_set) wel_q <= 1'b1;
    end

    assign wel = wel_q;

    ppb_cmd_tracker #(
        .PAGE_W    (PAGE_W),
        .PP_OPCODE (PP_OPCODE)
    ) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .mid_byte    (mid_byte),
        .busy        (busy),
        .wel         (wel_q),
        .buf_clr     (buf_clr),
        .buf_we      (buf_we),
        .buf_off     (buf_off),
        .buf_wdata   (buf_wdata),
        .commit      (commit),
        .commit_page (commit_page)
    );

    ppb_page_buffer u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .we       (buf_we),
        .off      (buf_off),
        .wdata    (buf_wdata),
        .rd_off   (sweep_off),
        .rd_data  (sweep_data),
        .rd_valid (sweep_valid)
    );

    ppb_array_engine #(
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_page (commit_page),
        .buf_data    (sweep_data),
        .buf_valid   (sweep_valid),
        .buf_rd_off  (sweep_off),
        .busy        (busy),
        .done        (done),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    p_wel_clears_with_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);

    p_commit_raises_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
endmodule

// File: tb/test_ppb_page_program.sv
`timescale 1ns/1ps
// Self-checking bench: every command's effect is predicted in a
// bench-side array model and compared over the full array.
module test_ppb_page_program;
    localparam int PAGES = 4;
    localparam int PROG  = 32;
    localparam int DEPTH = PAGES * 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       mid_byte = 1'b0;
    logic       wel_set = 1'b0;
    logic       wel;
    logic       busy;
    logic [9:0] rd_addr = 10'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    ppb_page_program #(.ARRAY_PAGES(PAGES), .PROG_CYCLES(PROG)) i_ppb_page_program (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .byte_valid(byte_valid),
        .byte_data(byte_data), .mid_byte(mid_byte), .wel_set(wel_set),
        .wel(wel), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int seed, input int k);
        return 8'(((seed * 29) + (k * 13) + ((k >> 4) * 7)) ^ 8'h5A);
    endfunction

    task automatic check_array(input string req);
        int bad = -1;
        logic [7:0] got = 8'd0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = 10'(a);
            #0.001;
            if (bad < 0 && rd_data !== ref_mem[a]) begin
                bad = a;
                got = rd_data;
            end
        end
        if (bad >= 0) chk(1'b0, {req, " array byte"}, int'(got), int'(ref_mem[bad]));
        else          chk(1'b1, req, 0, 0);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic pulse_wel;
        @(negedge clk);
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
    endtask

    // Send a full command; raise chip select (optionally mid-byte).
    task automatic issue(input logic [7:0] op, input logic [23:0] addr, input int naddr,
                         input int n, input int seed, input bit partial);
        @(negedge clk);
        sel_n = 1'b0;
        send_byte(op);
        for (int i = 0; i < naddr; i++) send_byte(addr[23-8*i -: 8]);
        for (int k = 0; k < n; k++) send_byte(dat(seed, k));
        @(negedge clk);
        sel_n    = 1'b1;
        mid_byte = partial;
        @(negedge clk);
        mid_byte = 1'b0;
    endtask

    // Apply a predicted commit to the bench model.
    task automatic model_commit(input logic [23:0] addr, input int n, input int seed);
        logic [7:0] fin [256];
        bit         hit [256];
        int         pg = int'(addr[9:8]);
        for (int o = 0; o < 256; o++) begin
            hit[o] = 1'b0;
            fin[o] = 8'd0;
        end
        for (int k = 0; k < n; k++) begin
            int o = (int'(addr[7:0]) + k) % 256;
            fin[o] = dat(seed, k);
            hit[o] = 1'b1;
        end
        for (int o = 0; o < 256; o++)
            if (hit[o]) ref_mem[pg*256 + o] = ref_mem[pg*256 + o] & fin[o];
    endtask

    // Check busy over the commit window (already one cycle after the rise).
    task automatic measure_busy(input string req);
        int cnt = 0;
        chk(busy === 1'b1, {req, " busy after rise"}, int'(busy), 1);
        while (busy === 1'b1 && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 256 + PROG, {req, " busy length"}, cnt, 256 + PROG);
        chk(wel === 1'b0, {req, " wel after done"}, int'(wel), 0);
    endtask

    task automatic good_pp(input logic [23:0] addr, input int n, input int seed, input string req);
        pulse_wel();
        chk(wel === 1'b1, "R2 wel set", int'(wel), 1);
        issue(8'h02, addr, 3, n, seed, 1'b0);
        model_commit(addr, n, seed);
        measure_busy("R10");
        check_array(req);
    endtask

    task automatic bad_cmd(input logic [7:0] op, input logic [23:0] addr, input int naddr,
                           input int n, input bit partial, input string req);
        issue(op, addr, naddr, n, 7, partial);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, {req, " no busy"}, int'(busy), 0);
        check_array(req);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(wel === 1'b0, "R1 wel", int'(wel), 0);
        check_array("R1");

        // R2 no write enable
        bad_cmd(8'h02, 24'h000110, 3, 5, 1'b0, "R2");

        // R6/R3 short program; high address bits ignored
        good_pp(24'hA31510, 5, 1, "R6 R3");
        // R4 wrap within page
        good_pp(24'h0002F0, 40, 2, "R4");
        // R5 more than a page
        good_pp(24'h000380, 300, 3, "R5");
        // R8 AND over earlier data
        good_pp(24'h000112, 6, 4, "R8");

        // R7 chip select mid-byte
        pulse_wel();
        bad_cmd(8'h02, 24'h000000, 3, 3, 1'b1, "R7");
        chk(wel === 1'b1, "R7 wel kept", int'(wel), 1);
        // R9 no data, truncated address
        bad_cmd(8'h02, 24'h000040, 3, 0, 1'b0, "R9 nodata");
        bad_cmd(8'h02, 24'h000040, 2, 0, 1'b0, "R9 shortaddr");
        // R3 wrong opcode
        bad_cmd(8'h03, 24'h000000, 3, 4, 1'b0, "R3 opcode");

        // R11 command during busy is ignored
        issue(8'h02, 24'h000220, 3, 20, 5, 1'b0);
        model_commit(24'h000220, 20, 5);
        chk(busy === 1'b1, "R11 busy", int'(busy), 1);
        @(negedge clk);
        sel_n = 1'b0;
        send_byte(8'h02);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h18);
        for (int k = 0; k < 16; k++) send_byte(8'h00);
        @(negedge clk);
        sel_n = 1'b1;
        while (busy === 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R11 stays idle", int'(busy), 0);
        check_array("R11");

        // R4/R5/R6 sweep of start offsets and lengths on page 0
        for (int i = 0; i < 8; i++)
            good_pp({14'd0, 2'd0, 8'((i * 37 + 200) % 256)}, i * 45 + 1, 10 + i, "R4 R5 R6 sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule